// File: doc/BRIEF.md
# Two-Partition Flash Command Controller

This block models the command side of a NOR flash that is split into two independently operating partitions. The host issues bus writes carrying an 8-bit command code and a full word address. The top address bit chooses the partition. The upper address bits name the erase block. The low sixteen bits carry a configuration value when one is being loaded.

Each partition runs its own state machine. The states are idle, program setup, erase setup, programming, erasing, program suspended and erase suspended. Each partition also remembers which view a read should return: array data, status register, or identifier words. Reads are decoded combinationally.

The design supports read-while-write: one partition can be read normally while the other is busy. A program can also be nested inside an erase suspend, and that program can itself be suspended. Program and erase durations are modelled by per-partition down-counters.

A shared configuration register selects synchronous burst or asynchronous reads.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset both partitions are idle, return array data (`arr_rdata`) on reads, and report status 0x80. The configuration register holds 0x8000, so `burst_mode` is 0.
- R2: A write affects only the partition selected by `wr_addr[ADDR_W-1]`. Reads of the other partition are unaffected, including while the selected partition is busy.
- R3: Command 0xFF selects the array view, 0x70 the status view, and 0x90 the identifier view.
  - In the identifier view, partition offsets 0, 1 and 2 return `MFR_ID`, `DEV_ID` and the configuration register.
  - Any other offset returns 0.
- R4: Command 0x40 followed by a second write to the same partition starts a program.
  - Status bit 7 reads 0 for exactly `PROG_CYC` cycles, counted from the edge that takes the second write.
  - While busy, every read of that partition returns the status register.
- R5: Command 0x20 followed by 0xD0 starts an erase of the block named by `wr_addr[ADDR_W-1:ADDR_W-BLK_W]`, busy for `ERASE_CYC` cycles.
  - If 0x20 is followed by any other code, status bits 5 and 4 are set and the partition returns to idle.
- R6: Command 0xB0 during a program suspends it.
  - Status reads 0x84 (bit 7 ready, bit 2 program suspended) and the view switches to array.
  - Command 0xD0 resumes the program with its remaining cycle count.
- R7: Command 0xB0 during an erase suspends it.
  - Status bit 6 is then 1 and the view switches to array.
  - A program to another block may run, and may itself be suspended and resumed; when it completes, the partition returns to erase suspend.
  - A later 0xD0 resumes the erase, which completes and leaves the partition idle.
- R8: A program whose data write addresses the erase-suspended block sets status bit 4 and is not performed: the partition stays ready and erase-suspended.
- R9: Command 0x50 clears status bits 5 and 4.
- R10: Command 0x60 followed by 0x03 loads `wr_addr[15:0]` into the configuration register.
  - `burst_mode` is the inverse of configuration bit 15.
  - If 0x60 is followed by any other code, the register is unchanged, and that second write has no effect on any partition.
- R11: Codes that do not apply in the current state are ignored. Examples are 0xB0 or 0xD0 while idle, and anything except 0xB0 while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | One-cycle command write strobe |
| wr_addr | input | ADDR_W | Command address: partition, block, configuration value |
| wr_cmd | input | 8 | Command code or program data byte |
| rd_addr | input | ADDR_W | Read address |
| arr_rdata | input | DATA_W | Array data for `rd_addr` from the storage model |
| rd_data | output | DATA_W | Read result for `rd_addr` |
| burst_mode | output | 1 | 1 when synchronous burst reads are selected |
| part_ready | output | 2 | Per-partition ready flag (status bit 7) |

## Verification
The properties assume several things about the inputs:
- `wr_en` is a single-cycle pulse with known values at every rising edge.
- `rd_addr` only changes away from the active edge.
- Reset is held for at least two clock cycles.

The bench respects these assumptions. It changes every input on the falling edge, pulses `wr_en` for exactly one cycle per command, and holds `rst_n` low for three cycles. It then waits for the internal reset release before issuing any command, so no write is lost during synchronisation.

// File: rtl/fcc_pkg.sv
package fcc_pkg;

  typedef enum logic [2:0] {
    OP_IDLE, OP_PSETUP, OP_ESETUP, OP_PROG, OP_ERASE, OP_PSUSP, OP_ESUSP
  } op_e;

  typedef enum logic [1:0] {VW_ARRAY, VW_STATUS, VW_ID} view_e;

  localparam logic [7:0] CMD_READ_ARRAY  = 8'hFF;
  localparam logic [7:0] CMD_READ_STATUS = 8'h70;
  localparam logic [7:0] CMD_READ_ID     = 8'h90;
  localparam logic [7:0] CMD_CLR_STATUS  = 8'h50;
  localparam logic [7:0] CMD_PROG        = 8'h40;
  localparam logic [7:0] CMD_ERASE       = 8'h20;
  localparam logic [7:0] CMD_CONFIRM     = 8'hD0;
  localparam logic [7:0] CMD_SUSPEND     = 8'hB0;
  localparam logic [7:0] CMD_CFG_SETUP   = 8'h60;
  localparam logic [7:0] CMD_CFG_LOAD    = 8'h03;

  localparam int SR_READY = 7;

endpackage

// File: rtl/fcc_partition.sv
module fcc_partition
  import fcc_pkg::*;
#(
  parameter int BLK_W     = 4,
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_hit,
  input  logic [7:0]       cmd_code,
  input  logic [BLK_W-1:0] cmd_blk,
  output view_e            view_o,
  output logic [7:0]       status_o,
  output logic             setup_o
);

  localparam int PCW = $clog2(PROG_CYC + 1);
  localparam int ECW = $clog2(ERASE_CYC + 1);
  localparam logic [PCW-1:0] P_LOAD = PCW'(PROG_CYC);
  localparam logic [PCW-1:0] P_ONE  = PCW'(1);
  localparam logic [ECW-1:0] E_LOAD = ECW'(ERASE_CYC);
  localparam logic [ECW-1:0] E_ONE  = ECW'(1);

  op_e              op_q, op_d;
  view_e            view_q, view_d;
  logic             held_q, held_d;
  logic [BLK_W-1:0] hblk_q, hblk_d;
  logic             perr_q, perr_d, eerr_q, eerr_d;
  logic [PCW-1:0]   pcnt_q, pcnt_d;
  logic [ECW-1:0]   ecnt_q, ecnt_d;
  logic             suspend_req;

  assign suspend_req = cmd_hit && (cmd_code == CMD_SUSPEND);

  always_comb begin
    op_d   = op_q;
    view_d = view_q;
    held_d = held_q;
    hblk_d = hblk_q;
    perr_d = perr_q;
    eerr_d = eerr_q;
    pcnt_d = pcnt_q;
    ecnt_d = ecnt_q;
    case (op_q)
      OP_PROG: begin
        if (pcnt_q == P_ONE) begin
          op_d = held_q ? OP_ESUSP : OP_IDLE;
        end else if (suspend_req) begin
          op_d   = OP_PSUSP;
          view_d = VW_ARRAY;
        end else begin
          pcnt_d = pcnt_q - P_ONE;
        end
      end
      OP_ERASE: begin
        if (ecnt_q == E_ONE) begin
          op_d = OP_IDLE;
        end else if (suspend_req) begin
          op_d   = OP_ESUSP;
          view_d = VW_ARRAY;
          held_d = 1'b1;
        end else begin
          ecnt_d = ecnt_q - E_ONE;
        end
      end
      OP_PSETUP: begin
        if (cmd_hit) begin
          if (held_q && (cmd_blk == hblk_q)) begin
            perr_d = 1'b1;
            op_d   = OP_ESUSP;
          end else begin
            op_d   = OP_PROG;
            pcnt_d = P_LOAD;
          end
        end
      end
      OP_ESETUP: begin
        if (cmd_hit) begin
          if (cmd_code == CMD_CONFIRM) begin
            op_d   = OP_ERASE;
            ecnt_d = E_LOAD;
            hblk_d = cmd_blk;
          end else begin
            op_d   = OP_IDLE;
            eerr_d = 1'b1;
            perr_d = 1'b1;
          end
        end
      end
      default: begin
        if (cmd_hit) begin
          case (cmd_code)
            CMD_READ_ARRAY:  view_d = VW_ARRAY;
            CMD_READ_STATUS: view_d = VW_STATUS;
            CMD_READ_ID:     view_d = VW_ID;
            CMD_CLR_STATUS: begin
              perr_d = 1'b0;
              eerr_d = 1'b0;
            end
            CMD_PROG: begin
              if (op_q != OP_PSUSP) begin
                op_d   = OP_PSETUP;
                view_d = VW_STATUS;
              end
            end
            CMD_ERASE: begin
              if (op_q == OP_IDLE) begin
                op_d   = OP_ESETUP;
                view_d = VW_STATUS;
              end
            end
            CMD_CONFIRM: begin
              if (op_q == OP_PSUSP) begin
                op_d = OP_PROG;
              end else if (op_q == OP_ESUSP) begin
                op_d   = OP_ERASE;
                held_d = 1'b0;
              end
            end
            default: ;
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_IDLE;
      view_q <= VW_ARRAY;
      held_q <= 1'b0;
      hblk_q <= '0;
      perr_q <= 1'b0;
      eerr_q <= 1'b0;
      pcnt_q <= '0;
      ecnt_q <= '0;
    end else begin
      op_q   <= op_d;
      view_q <= view_d;
      held_q <= held_d;
      hblk_q <= hblk_d;
      perr_q <= perr_d;
      eerr_q <= eerr_d;
      pcnt_q <= pcnt_d;
      ecnt_q <= ecnt_d;
    end
  end

  assign view_o   = view_q;
  assign setup_o  = (op_q == OP_PSETUP) || (op_q == OP_ESETUP);
  assign status_o = {!((op_q == OP_PROG) || (op_q == OP_ERASE)), held_q,
                     eerr_q, perr_q, 1'b0, (op_q == OP_PSUSP), 2'b00};

endmodule

// File: rtl/fcc_cfg.sv
module fcc_cfg
  import fcc_pkg::*;
#(
  parameter int               CFG_W   = 16,
  parameter logic [CFG_W-1:0] CFG_RST = 16'h8000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_cmd,
  input  logic [CFG_W-1:0] wr_val,
  input  logic             tgt_setup,
  output logic [CFG_W-1:0] cfg_o,
  output logic             pend_o
);

  logic             pend_q, pend_d, cfg_we;
  logic [CFG_W-1:0] cfg_q;

  always_comb begin
    pend_d = pend_q;
    cfg_we = 1'b0;
    if (wr_en) begin
      if (pend_q) begin
        pend_d = 1'b0;
        cfg_we = (wr_cmd == CMD_CFG_LOAD);
      end else if ((wr_cmd == CMD_CFG_SETUP) && !tgt_setup) begin
        pend_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      cfg_q  <= CFG_RST;
    end else begin
      pend_q <= pend_d;
      if (cfg_we) cfg_q <= wr_val;
    end
  end

  assign cfg_o  = cfg_q;
  assign pend_o = pend_q;

endmodule

// File: rtl/fcc_read_mux.sv
module fcc_read_mux
  import fcc_pkg::*;
#(
  parameter int                DATA_W = 16,
  parameter int                CFG_W  = 16,
  parameter logic [DATA_W-1:0] MFR_ID = 16'h00C3,
  parameter logic [DATA_W-1:0] DEV_ID = 16'h7E21
) (
  input  view_e             view,
  input  logic [7:0]        status,
  input  logic              id_base,
  input  logic [1:0]        id_sel,
  input  logic [DATA_W-1:0] arr_rdata,
  input  logic [CFG_W-1:0]  cfg,
  output logic [DATA_W-1:0] rd_data
);

  always_comb begin
    rd_data = arr_rdata;
    if (!status[SR_READY]) begin
      rd_data = DATA_W'(status);
    end else begin
      case (view)
        VW_STATUS: rd_data = DATA_W'(status);
        VW_ID: begin
          rd_data = '0;
          if (id_base) begin
            case (id_sel)
              2'd0:    rd_data = MFR_ID;
              2'd1:    rd_data = DEV_ID;
              2'd2:    rd_data = DATA_W'(cfg);
              default: rd_data = '0;
            endcase
          end
        end
        default: rd_data = arr_rdata;
      endcase
    end
  end

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import fcc_pkg::*;
#(
  parameter int                ADDR_W    = 20,
  parameter int                DATA_W    = 16,
  parameter int                BLK_W     = 4,
  parameter int                CFG_W     = 16,
  parameter int                PROG_CYC  = 8,
  parameter int                ERASE_CYC = 40,
  parameter logic [CFG_W-1:0]  CFG_RST   = 16'h8000,
  parameter logic [DATA_W-1:0] MFR_ID    = 16'h00C3,
  parameter logic [DATA_W-1:0] DEV_ID    = 16'h7E21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_cmd,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              burst_mode,
  output logic [1:0]        part_ready
);

  localparam int PB       = ADDR_W - 1;
  localparam int MODE_BIT = CFG_W - 1;
  localparam int NPART    = 2;

  logic [1:0]       rst_pipe;
  logic             rst_sync_n;
  logic             wr_part, rd_part, cfg_pend;
  logic [CFG_W-1:0] cfg;
  logic [NPART-1:0] part_setup;
  view_e            part_view   [NPART];
  logic [7:0]       part_status [NPART];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  assign wr_part = wr_addr[PB];
  assign rd_part = rd_addr[PB];

  for (genvar g = 0; g < NPART; g++) begin : g_part
    fcc_partition #(
      .BLK_W(BLK_W), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
    ) u_part (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .cmd_hit  (wr_en && !cfg_pend && (wr_part == 1'(g))),
      .cmd_code (wr_cmd),
      .cmd_blk  (wr_addr[PB -: BLK_W]),
      .view_o   (part_view[g]),
      .status_o (part_status[g]),
      .setup_o  (part_setup[g])
    );
    assign part_ready[g] = part_status[g][SR_READY];
  end

  fcc_cfg #(.CFG_W(CFG_W), .CFG_RST(CFG_RST)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (wr_en),
    .wr_cmd    (wr_cmd),
    .wr_val    (wr_addr[CFG_W-1:0]),
    .tgt_setup (part_setup[wr_part]),
    .cfg_o     (cfg),
    .pend_o    (cfg_pend)
  );

  fcc_read_mux #(
    .DATA_W(DATA_W), .CFG_W(CFG_W), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)
  ) u_rmux (
    .view      (part_view[rd_part]),
    .status    (part_status[rd_part]),
    .id_base   (rd_addr[PB-1:2] == '0),
    .id_sel    (rd_addr[1:0]),
    .arr_rdata (arr_rdata),
    .cfg       (cfg),
    .rd_data   (rd_data)
  );

  assign burst_mode = !cfg[MODE_BIT];

endmodule

// File: rtl/fcc_checker.sv
module fcc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       wr_part,
  input logic [7:0] wr_cmd,
  input logic       rd_part,
  input logic       rd_bit7,
  input logic [1:0] part_ready,
  input logic       burst_mode,
  input logic       p0_psusp,
  input logic       p1_psusp,
  input logic       p1_held,
  input logic       p0_eerr,
  input logic       p0_perr,
  input logic [1:0] view1
);

  // R4: a busy partition never exposes array data, so bit 7 of a read is 0
  a_r4_busy_reads_status: assert property (@(posedge clk) disable iff (!rst_n)
    !part_ready[rd_part] |-> !rd_bit7);

  // R6: a suspended program leaves the partition ready
  a_r6_p0_susp_ready: assert property (@(posedge clk) disable iff (!rst_n)
    p0_psusp |-> part_ready[0]);
  a_r6_p1_susp_ready: assert property (@(posedge clk) disable iff (!rst_n)
    p1_psusp |-> part_ready[1]);

  // R7: the erase-suspend flag drops only after a resume aimed at partition 1
  a_r7_hold_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(p1_held) |-> $past(wr_en && wr_part && (wr_cmd == 8'hD0)));

  // R2: partition 1 read view moves only after a write aimed at it
  a_r2_view_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en && wr_part) |-> $stable(view1));

  // R5: an erase-sequence error always carries the program-error flag
  a_r5_err_pair: assert property (@(posedge clk) disable iff (!rst_n)
    p0_eerr |-> p0_perr);

  // R10: the read mode changes only after a write
  a_r10_mode_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(burst_mode) |-> $past(wr_en));

endmodule

bind flash_cmd_ctrl fcc_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .wr_en      (wr_en),
  .wr_part    (wr_addr[ADDR_W-1]),
  .wr_cmd     (wr_cmd),
  .rd_part    (rd_addr[ADDR_W-1]),
  .rd_bit7    (rd_data[7]),
  .part_ready (part_ready),
  .burst_mode (burst_mode),
  .p0_psusp   (part_status[0][2]),
  .p1_psusp   (part_status[1][2]),
  .p1_held    (part_status[1][6]),
  .p0_eerr    (part_status[0][5]),
  .p0_perr    (part_status[0][4]),
  .view1      (part_view[1])
);

// File: tb/sim_flash_cmd_ctrl.sv
module sim_flash_cmd_ctrl;

  localparam int PROG_CYC  = 8;
  localparam int ERASE_CYC = 40;
  localparam int NV        = 25;

  logic        clk, rst_n, wr_en, burst_mode;
  logic [19:0] wr_addr, rd_addr;
  logic [7:0]  wr_cmd;
  logic [15:0] arr_rdata, rd_data;
  logic [1:0]  part_ready;
  int          n_chk, n_fail;
  bit          done;

  flash_cmd_ctrl #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_cmd(wr_cmd), .rd_addr(rd_addr), .arr_rdata(arr_rdata),
    .rd_data(rd_data), .burst_mode(burst_mode), .part_ready(part_ready)
  );

  assign arr_rdata = rd_addr[15:0] ^ 16'hA5A5;

  initial begin
    clk = 1'b0;
    forever #10 clk = ~clk;
  end

  // {kind(1: read check), requirement number, address, command or expected}
  localparam logic [40:0] VEC [NV] = '{
    {1'b0, 4'd3,  20'h00000, 16'h0090},  // R3 identifier view
    {1'b1, 4'd3,  20'h00000, 16'h00C3},
    {1'b1, 4'd3,  20'h00001, 16'h7E21},
    {1'b1, 4'd3,  20'h00002, 16'h8000},
    {1'b1, 4'd2,  20'h80010, 16'hA5B5},  // R2 other partition untouched
    {1'b0, 4'd3,  20'h00000, 16'h0070},
    {1'b1, 4'd3,  20'h00400, 16'h0080},
    {1'b0, 4'd5,  20'h00000, 16'h0020},  // R5 bad erase confirm
    {1'b0, 4'd5,  20'h00000, 16'h00FF},
    {1'b1, 4'd5,  20'h00000, 16'h00B0},
    {1'b0, 4'd9,  20'h00000, 16'h0050},  // R9 clear errors
    {1'b1, 4'd9,  20'h00000, 16'h0080},
    {1'b0, 4'd11, 20'h00000, 16'h00B0},  // R11 suspend when idle
    {1'b1, 4'd11, 20'h00000, 16'h0080},
    {1'b0, 4'd11, 20'h00000, 16'h00D0},  // R11 resume when idle
    {1'b1, 4'd11, 20'h00000, 16'h0080},
    {1'b0, 4'd3,  20'h01234, 16'h00FF},
    {1'b1, 4'd3,  20'h01234, 16'hB791},
    {1'b0, 4'd10, 20'h80000, 16'h0060},  // R10 load configuration
    {1'b0, 4'd10, 20'h07ABC, 16'h0003},
    {1'b0, 4'd10, 20'h00000, 16'h0090},
    {1'b1, 4'd10, 20'h00002, 16'h7ABC},
    {1'b0, 4'd10, 20'h00000, 16'h0060},  // R10 aborted load
    {1'b0, 4'd10, 20'h0FFFF, 16'h00FF},
    {1'b1, 4'd10, 20'h00002, 16'h7ABC}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [19:0] a, input logic [7:0] c);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_cmd = c;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [19:0] a, input logic [15:0] exp, input string req);
    rd_addr = a;
    #1;
    chk(req, rd_data, exp);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog all requirements actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_cmd = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 ready", {14'd0, part_ready}, 16'h0003);
    chk("R1 mode", {15'd0, burst_mode}, 16'h0000);
    rd(20'h01234, 16'hB791, "R1 p0 array");
    rd(20'h80010, 16'hA5B5, "R1 p1 array");

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][40]) rd(VEC[i][35:16], VEC[i][15:0], $sformatf("R%0d vec%0d", VEC[i][39:36], i));
      else            wr(VEC[i][35:16], VEC[i][7:0]);
    end
    chk("R10 burst selected", {15'd0, burst_mode}, 16'h0001);

    // R4 program timing and read-while-write
    wr(20'h00100, 8'h40);
    wr(20'h00100, 8'h11);
    chk("R4 busy", {15'd0, part_ready[0]}, 16'h0000);
    rd(20'h00100, 16'h0000, "R4 busy status");
    rd(20'h80010, 16'hA5B5, "R2 read other while busy");
    wr(20'h00100, 8'hFF);  // R11 ignored while busy
    rd(20'h00100, 16'h0000, "R11 busy ignores read array");
    repeat (PROG_CYC - 3) @(negedge clk);
    chk("R4 last busy cycle", {15'd0, part_ready[0]}, 16'h0000);
    @(negedge clk);
    chk("R4 done", {15'd0, part_ready[0]}, 16'h0001);
    rd(20'h00100, 16'h0080, "R4 status after");

    // R6 program suspend and resume
    wr(20'h00200, 8'h40);
    wr(20'h00200, 8'h22);
    repeat (2) @(negedge clk);
    wr(20'h00200, 8'hB0);
    rd(20'h00200, 16'hA7A5, "R6 suspended array read");
    wr(20'h00200, 8'h70);
    rd(20'h00200, 16'h0084, "R6 suspended status");
    wr(20'h00200, 8'hD0);
    chk("R6 resumed busy", {15'd0, part_ready[0]}, 16'h0000);
    repeat (PROG_CYC - 4) @(negedge clk);
    chk("R6 remaining busy", {15'd0, part_ready[0]}, 16'h0000);
    @(negedge clk);
    chk("R6 resumed done", {15'd0, part_ready[0]}, 16'h0001);

    // R7 / R8 erase suspend on partition 1 with nested program
    wr(20'h00000, 8'hFF);
    wr(20'h80000, 8'h20);
    wr(20'h80000, 8'hD0);
    chk("R5 erase busy", {15'd0, part_ready[1]}, 16'h0000);
    rd(20'h01234, 16'hB791, "R2 p0 array during erase");
    repeat (3) @(negedge clk);
    wr(20'h80000, 8'hB0);
    rd(20'h80010, 16'hA5B5, "R7 erase-suspended array read");
    wr(20'h80000, 8'h70);
    rd(20'h80000, 16'h00C0, "R7 erase-suspended status");
    wr(20'h80044, 8'h40);
    wr(20'h80044, 8'h33);
    rd(20'h80000, 16'h00D0, "R8 program to held block rejected");
    chk("R8 stays ready", {15'd0, part_ready[1]}, 16'h0001);
    wr(20'h80000, 8'h50);
    rd(20'h80000, 16'h00C0, "R9 clear after R8");
    wr(20'h90020, 8'h40);
    wr(20'h90020, 8'h44);
    rd(20'h80000, 16'h0040, "R7 nested program busy");
    wr(20'h90020, 8'hB0);
    wr(20'h90020, 8'h70);
    rd(20'h80000, 16'h00C4, "R7 nested program suspended");
    wr(20'h90020, 8'hD0);
    repeat (PROG_CYC + 2) @(negedge clk);
    rd(20'h80000, 16'h00C0, "R7 back to erase suspend");
    wr(20'h80000, 8'hD0);
    chk("R7 erase resumed", {15'd0, part_ready[1]}, 16'h0000);
    repeat (ERASE_CYC + 2) @(negedge clk);
    chk("R7 erase done", {14'd0, part_ready}, 16'h0003);
    rd(20'h80000, 16'h0080, "R7 idle status");

    // R1 reset from a non-default state
    wr(20'h80000, 8'h90);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 mode after reset", {15'd0, burst_mode}, 16'h0000);
    rd(20'h80010, 16'hA5B5, "R1 p1 array after reset");
    rd(20'h00100, 16'hA4A5, "R1 p0 array after reset");

    done = 1'b1;
    summary();
    $finish;
  end

endmodule